// File: doc/BRIEF.md
# Edge-Compensated Pulse Timestamp Unit

This block timestamps a slow periodic pulse, such as a once-per-second reference, with the resolution of a prescaled tick. Two counters advance on that tick. The timebase counter runs freely and wraps. The elapsed counter is cleared when the synchronized pulse goes high and then counts the ticks since that edge. Software may poll at any time. The timestamp it gets back is the timebase minus the elapsed count, so the edge time is rebuilt exactly and the polling delay cancels out.

A poll is a one-cycle snapshot request. It captures the pulse level, the timebase and the elapsed count on the same clock edge. When the captured level is high and the level captured by the previous poll was low, the block produces a stamp and raises a valid flag. Reading the stamp clears that flag. An echo output follows the polled level changes, and its polarity can be inverted. If the elapsed counter saturates, a stale flag travels with the stamp.

Top module: `pulse_stamp_unit`

## Requirements
- R1: A tick occurs once every DIV clocks (default 4), with the first tick on the DIV-th rising clock edge after reset. The timebase counter (CNT_W bits, default 16) adds one on each tick and wraps from all ones to zero.
- R2: `pulse_in` passes through two synchronizer flops and one level register. A low-to-high change on `pulse_in` makes the registered level high, and clears the elapsed counter to zero, on the third rising clock edge after the change.
- R3: After it is cleared, the elapsed counter adds one on each tick. It stops at all ones and does not wrap.
- R4: While `snap_req` is high on a rising edge, `snap_level`, `snap_base` and `snap_elapsed` take the registered level, the timebase and the elapsed count of that same cycle. Each of them holds its value until the next request.
- R5: When a request captures a high level and the previous request captured a low level, `stamp_time` becomes (timebase − elapsed) mod 2^CNT_W and `stamp_valid` goes high, one edge after the request.
- R6: A request that captures a falling or unchanged level leaves `stamp_time` and `stamp_stale` as they were, and does not set `stamp_valid`.
- R7: `stamp_ack` high on an edge clears `stamp_valid`. When an acknowledge and a new stamp fall on the same edge, the new stamp wins and `stamp_valid` stays high.
- R8: Inside the block, the echo state goes high on a request that produces a stamp, and goes low on a request that captures a falling level. `echo_out` is that state XOR `echo_inv`. The echo state is low after reset.
- R9: The stale condition is set when the elapsed counter reaches all ones, and cleared by the next rising edge of the pulse. `stamp_stale` is loaded with this condition whenever a stamp is produced.
- R10: Reset (`rst_n` low, asynchronous) clears all counters, the snapshot outputs, `stamp_valid`, `stamp_stale` and the stored level of the previous request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pulse_in | input | 1 | Asynchronous pulse to timestamp |
| echo_inv | input | 1 | Inverts the echo output when high |
| snap_req | input | 1 | One-cycle poll request |
| stamp_ack | input | 1 | Stamp read; clears the valid flag |
| snap_level | output | 1 | Pulse level captured by the last poll |
| snap_base | output | CNT_W | Timebase captured by the last poll |
| snap_elapsed | output | CNT_W | Elapsed count captured by the last poll |
| stamp_time | output | CNT_W | Reconstructed edge time |
| stamp_valid | output | 1 | A stamp is waiting to be read |
| stamp_stale | output | 1 | The last stamp came from a saturated elapsed count |
| echo_out | output | 1 | Echo of the polled pulse edges |

## Verification
The assertions assume that `pulse_in` stays at each level long enough to pass through the synchronizer. They also assume that a poll sees each pulse level it is meant to classify. The stimulus therefore holds every pulse level for at least three clocks before the next change. It times polls both before and exactly at the cycle in which the registered level rises, and it makes no other assumption about when the pulse changes relative to the tick. The counter width is reduced on the bench so that saturation and timebase wrap fall inside a short run.

// File: rtl/pst_pkg.sv
package pst_pkg;

    typedef enum logic [1:0] {
        LVL_SAME = 2'd0,
        LVL_RISE = 2'd1,
        LVL_FALL = 2'd2
    } lvl_chg_e;

    function automatic lvl_chg_e classify_level(input logic now_lvl, input logic was_lvl);
        if (now_lvl && !was_lvl) return LVL_RISE;
        if (!now_lvl && was_lvl) return LVL_FALL;
        return LVL_SAME;
    endfunction

endpackage

// File: rtl/pst_prescaler.sv
module pst_prescaler #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);
    localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;

    logic [PW-1:0] cnt_d, cnt_q;

    generate
        if (DIV > 1) begin : g_div
            always_comb begin
                tick_o = (cnt_q == PW'(DIV - 1));
                cnt_d  = tick_o ? '0 : cnt_q + 1'b1;
            end
        end else begin : g_nodiv
            always_comb begin
                tick_o = 1'b1;
                cnt_d  = '0;
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/pst_sync_edge.sv
module pst_sync_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic lvl_o,
    output logic rise_o
);
    typedef struct packed {
        logic s1;
        logic s2;
        logic lvl;
    } sync_s;

    sync_s r_d, r_q;

    always_comb begin
        r_d     = r_q;
        r_d.s1  = async_i;
        r_d.s2  = r_q.s1;
        r_d.lvl = r_q.s2;
        lvl_o   = r_q.lvl;
        rise_o  = r_q.s2 & ~r_q.lvl;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end
endmodule

// File: rtl/pst_counters.sv
module pst_counters #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             clr_i,
    output logic [CNT_W-1:0] base_o,
    output logic [CNT_W-1:0] elapsed_o,
    output logic             stale_o
);
    localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

    typedef struct packed {
        logic [CNT_W-1:0] base;
        logic [CNT_W-1:0] elapsed;
        logic             stale;
    } cnt_s;

    cnt_s r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (tick_i) r_d.base = r_q.base + 1'b1;
        if (clr_i) begin
            r_d.elapsed = '0;
            r_d.stale   = 1'b0;
        end else if (tick_i && r_q.elapsed != TOP) begin
            r_d.elapsed = r_q.elapsed + 1'b1;
            if (r_q.elapsed == TOP - 1'b1) r_d.stale = 1'b1;
        end
        base_o    = r_q.base;
        elapsed_o = r_q.elapsed;
        stale_o   = r_q.stale;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end
endmodule

// File: rtl/pulse_stamp_unit.sv
module pulse_stamp_unit #(
    parameter int CNT_W = 16,
    parameter int DIV   = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pulse_in,
    input  logic             echo_inv,
    input  logic             snap_req,
    input  logic             stamp_ack,
    output logic             snap_level,
    output logic [CNT_W-1:0] snap_base,
    output logic [CNT_W-1:0] snap_elapsed,
    output logic [CNT_W-1:0] stamp_time,
    output logic             stamp_valid,
    output logic             stamp_stale,
    output logic             echo_out
);
    import pst_pkg::*;

    logic             tick_w, lvl_w, rise_w, stale_w;
    logic [CNT_W-1:0] base_w, elapsed_w;

    pst_prescaler #(.DIV(DIV)) u_presc (
        .clk(clk), .rst_n(rst_n), .tick_o(tick_w)
    );

    pst_sync_edge u_sync (
        .clk(clk), .rst_n(rst_n), .async_i(pulse_in),
        .lvl_o(lvl_w), .rise_o(rise_w)
    );

    pst_counters #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_w), .clr_i(rise_w),
        .base_o(base_w), .elapsed_o(elapsed_w), .stale_o(stale_w)
    );

    typedef struct packed {
        logic             last_lvl;
        logic             lvl;
        logic [CNT_W-1:0] base;
        logic [CNT_W-1:0] elapsed;
        logic [CNT_W-1:0] stamp;
        logic             valid;
        logic             stale;
        logic             echo;
    } snap_s;

    snap_s    r_d, r_q;
    lvl_chg_e chg_w;

    always_comb begin
        r_d   = r_q;
        chg_w = classify_level(lvl_w, r_q.last_lvl);
        if (stamp_ack) r_d.valid = 1'b0;
        if (snap_req) begin
            r_d.last_lvl = lvl_w;
            r_d.lvl      = lvl_w;
            r_d.base     = base_w;
            r_d.elapsed  = elapsed_w;
            case (chg_w)
                LVL_RISE: begin
                    r_d.stamp = base_w - elapsed_w;
                    r_d.valid = 1'b1;
                    r_d.stale = stale_w;
                    r_d.echo  = 1'b1;
                end
                LVL_FALL: r_d.echo = 1'b0;
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign snap_level   = r_q.lvl;
    assign snap_base    = r_q.base;
    assign snap_elapsed = r_q.elapsed;
    assign stamp_time   = r_q.stamp;
    assign stamp_valid  = r_q.valid;
    assign stamp_stale  = r_q.stale;
    assign echo_out     = r_q.echo ^ echo_inv;
endmodule

// File: rtl/pst_checker.sv
module pst_checker #(
    parameter int CNT_W = 16,
    parameter int DIV   = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick,
    input logic             rise,
    input logic             lvl,
    input logic             last_lvl,
    input logic             snap_req,
    input logic             stamp_ack,
    input logic [CNT_W-1:0] base,
    input logic [CNT_W-1:0] elapsed,
    input logic             stale,
    input logic [CNT_W-1:0] snap_base,
    input logic [CNT_W-1:0] snap_elapsed,
    input logic [CNT_W-1:0] stamp_time,
    input logic             stamp_valid,
    input logic             echo_state
);
    localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

    logic new_stamp;
    assign new_stamp = snap_req && lvl && !last_lvl;

    // R1
    base_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> base == CNT_W'($past(base) + 1'b1));
    // R1
    base_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(base));
    generate
        if (DIV > 1) begin : g_space
            // R1
            tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
                tick |=> !tick);
        end
    endgenerate
    // R2
    edge_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> elapsed == '0);
    // R3
    sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (elapsed == TOP && !rise) |=> elapsed == TOP);
    // R5
    stamp_calc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        new_stamp |=> stamp_valid && stamp_time == snap_base - snap_elapsed);
    // R6
    no_stamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !new_stamp |=> $stable(stamp_time));
    // R7
    ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stamp_ack && !new_stamp) |=> !stamp_valid);
    // R8
    echo_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        new_stamp |=> echo_state);
    // R8
    echo_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (snap_req && !lvl && last_lvl) |=> !echo_state);
    // R9
    stale_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        elapsed == TOP |-> stale);
endmodule

bind pulse_stamp_unit pst_checker #(.CNT_W(CNT_W), .DIV(DIV)) u_chk (
    .clk(clk), .rst_n(rst_n), .tick(tick_w), .rise(rise_w), .lvl(lvl_w),
    .last_lvl(r_q.last_lvl), .snap_req(snap_req), .stamp_ack(stamp_ack),
    .base(base_w), .elapsed(elapsed_w), .stale(stale_w),
    .snap_base(snap_base), .snap_elapsed(snap_elapsed),
    .stamp_time(stamp_time), .stamp_valid(stamp_valid), .echo_state(r_q.echo)
);

// File: tb/tb_pulse_stamp_unit.sv
module tb_pulse_stamp_unit;
    localparam int W    = 10;
    localparam int DV   = 4;
    localparam int MOD  = 1 << W;
    localparam int TOPV = MOD - 1;
    localparam int NV   = 11;
    // bit 15: pulse level to apply; bits 11:0: clocks to wait before polling
    localparam logic [15:0] VEC [NV] = '{
        16'h000A, 16'h8003, 16'h8014, 16'h0002, 16'h0009, 16'h8002,
        16'h8025, 16'h0005, 16'h8064, 16'h0032, 16'h8007
    };

    logic clk = 1'b0, rst_n = 1'b0;
    logic pulse_in = 1'b0, echo_inv = 1'b0, snap_req = 1'b0, stamp_ack = 1'b0;
    logic snap_level, stamp_valid, stamp_stale, echo_out;
    logic [W-1:0] snap_base, snap_elapsed, stamp_time;

    pulse_stamp_unit #(.CNT_W(W), .DIV(DV)) dut (
        .clk(clk), .rst_n(rst_n), .pulse_in(pulse_in), .echo_inv(echo_inv),
        .snap_req(snap_req), .stamp_ack(stamp_ack), .snap_level(snap_level),
        .snap_base(snap_base), .snap_elapsed(snap_elapsed), .stamp_time(stamp_time),
        .stamp_valid(stamp_valid), .stamp_stale(stamp_stale), .echo_out(echo_out)
    );

    always #2 clk = ~clk;   // 4-unit period stands for 250 MHz

    int edge_n;
    always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) edge_n <= 0;
        else        edge_n <= edge_n + 1;

    int n_vec = 0, n_bad = 0;
    logic done = 1'b0;

    // bench model state
    logic cur_p = 0, prev_p = 0, m_last = 0, m_valid = 0, m_stale = 0, m_echo = 0;
    int   chg_at = -100, rise_at = 0, prev_rise = 0, m_stamp = 0;

    task automatic chk(input string req, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic set_pulse(input logic v);
        if (v != cur_p) begin
            prev_p = cur_p;
            cur_p  = v;
            chg_at = edge_n;
            if (v) begin
                prev_rise = rise_at;
                rise_at   = edge_n + 3;
            end
        end
        pulse_in = v;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic poll(input logic with_ack);
        int k, r, el_raw, el, bs;
        logic lv, st, rising, falling;
        k      = edge_n;
        lv     = (k >= chg_at + 3) ? cur_p : prev_p;
        r      = (k >= rise_at) ? rise_at : prev_rise;
        el_raw = k / DV - r / DV;
        el     = (el_raw > TOPV) ? TOPV : el_raw;
        st     = (el_raw >= TOPV);
        bs     = (k / DV) % MOD;
        rising  = lv && !m_last;
        falling = !lv && m_last;
        snap_req  = 1'b1;
        stamp_ack = with_ack;
        @(negedge clk);
        snap_req  = 1'b0;
        stamp_ack = 1'b0;
        m_last = lv;
        if (with_ack) m_valid = 1'b0;
        if (rising) begin
            m_stamp = (bs - el + MOD) % MOD;
            m_valid = 1'b1;
            m_stale = st;
            m_echo  = 1'b1;
        end
        if (falling) m_echo = 1'b0;
        chk("R2/R4 level", int'(snap_level), int'(lv));
        chk("R1/R4 timebase", int'(snap_base), bs);
        chk("R3/R4 elapsed", int'(snap_elapsed), el);
        chk("R5/R6 stamp", int'(stamp_time), m_stamp);
        chk("R5/R7 valid", int'(stamp_valid), int'(m_valid));
        chk("R9 stale", int'(stamp_stale), int'(m_stale));
        chk("R8 echo", int'(echo_out), int'(m_echo ^ echo_inv));
    endtask

    initial begin
        idle(3);
        chk("R10 reset valid", int'(stamp_valid), 0);
        chk("R10 reset stamp", int'(stamp_time), 0);
        chk("R10 reset base", int'(snap_base), 0);
        chk("R8 reset echo", int'(echo_out), 0);
        rst_n = 1'b1;
        // table walk: R1..R8
        for (int i = 0; i < NV; i++) begin
            set_pulse(VEC[i][15]);
            idle(int'(VEC[i][11:0]));
            poll(1'b0);
        end
        // R7: acknowledge clears valid
        poll(1'b1);
        chk("R7 cleared", int'(stamp_valid), 0);
        // R7: acknowledge and new stamp on the same edge
        set_pulse(1'b0); idle(6); poll(1'b0);
        set_pulse(1'b1); idle(9); poll(1'b1);
        chk("R7 new stamp wins", int'(stamp_valid), 1);
        // R8: inverted echo
        echo_inv = 1'b1; #1;
        chk("R8 inverted high", int'(echo_out), 0);
        set_pulse(1'b0); idle(6); poll(1'b0);
        chk("R8 inverted low", int'(echo_out), 1);
        echo_inv = 1'b0;
        // R3/R9: saturation, stale stamp, timebase wrap (R1)
        set_pulse(1'b1); idle(TOPV * DV + 60); poll(1'b1);
        chk("R3 saturated", int'(snap_elapsed), TOPV);
        chk("R9 stale set", int'(stamp_stale), 1);
        idle(30); poll(1'b0);
        chk("R3 still saturated", int'(snap_elapsed), TOPV);
        // R9: next rising edge clears stale
        set_pulse(1'b0); idle(8); poll(1'b1);
        set_pulse(1'b1); idle(21); poll(1'b0);
        chk("R9 stale cleared", int'(stamp_stale), 0);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            n_vec++;
            n_bad++;
            $display("FAIL watchdog: actual running expected done");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule